// File: doc/BRIEF.md
# Dual-Phase Serial Audio Transmitter

This block turns parallel PCM samples into a serial bit stream for an audio link. It does not make its own serial clock. A one-cycle strobe, `bit_tick`, marks each falling edge of the external bit clock, and the block changes its output only at those points. The far end samples on the rising edge that follows. The frame-sync level `fsync` is sampled at every tick. A rising edge on `fsync` opens phase one. When dual-phase framing is selected, a falling edge opens phase two. This gives stereo I2S and left-justified streams, with one word per phase. All other formats use a single phase that carries one word per channel. DSP-style multichannel streams of up to 16 channels are among them.

At the start of each word, the block takes a sample through a ready/valid handshake. It shifts the word out MSB first, using the word length chosen by a 3-bit code. After a frame-sync edge, the first bit comes either at once (0-bit delay) or one bit later (1-bit delay). The line is held low after the last word of a phase until the next phase starts. If no sample is offered when a word begins, the block sends a zero word and raises an underflow pulse.

Top module: `dual_phase_tx`

## Requirements
- R1: `cfg_wlen` selects the word length: 0 gives 8 bits, 1 gives 12, 2 gives 16, 3 gives 20, 4 gives 24 and 5 gives 32. Codes 6 and 7 also give 32. Only the low W bits of `s_data` are sent, most significant bit first, one bit per tick.
- R2: `cfg_frlen` (7 bits) holds the number of words per phase minus one, sent back to back. Frames of 16 words are supported.
- R3: When `cfg_dual` is 1, a rising `fsync` at a tick starts phase one and a falling `fsync` at a tick starts phase two. Each phase carries `cfg_frlen`+1 words.
- R4: When `cfg_dual` is 0, only a rising `fsync` starts a phase. A falling `fsync` starts no word and takes no sample.
- R5: When `cfg_delay` is 0, the MSB of the first word of a phase is driven at the tick where the phase starts.
- R6: When `cfg_delay` is 1, the tick where a phase starts drives 0, and the first MSB follows at the next tick.
- R7: From the tick after the last bit of the last word of a phase, `sdata_out` is 0 until the next phase starts.
- R8: If `s_valid` is low in the tick cycle where a word starts, the word is sent as all zeros and `underflow` is high for exactly the one clock cycle that follows. The word slot is used up all the same.
- R9: `s_ready` is high only in a tick cycle where a word starts. `sdata_out` changes only in the clock cycle right after a tick.
- R10: A phase start that comes while a word is still being sent ends that word at once and begins the new phase.
- R11: Under reset, `sdata_out`, `underflow` and `s_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe at each falling bit-clock edge |
| fsync | input | 1 | Frame-sync level, active high, sampled at ticks |
| cfg_wlen | input | 3 | Word-length code |
| cfg_frlen | input | 7 | Words per phase minus one |
| cfg_dual | input | 1 | 1 selects dual-phase framing |
| cfg_delay | input | 1 | Data delay after frame-sync: 0 or 1 bit |
| s_data | input | 32 | Sample, right-aligned |
| s_valid | input | 1 | Sample is offered |
| s_ready | output | 1 | Sample taken in this cycle |
| sdata_out | output | 1 | Serial data |
| underflow | output | 1 | One-cycle pulse when a word started with no sample |

## Verification
The bench runs four framings against a per-tick bit model:
- I2S with a 1-bit delay.
- Left-justified 32-bit words with the second phase starting right after the first word's last bit.
- DSP with a 1-bit delay.
- DSP with no delay.

A design that got the delay wrong would shift every bit by one tick. A design that started a word on the falling `fsync` in single-phase mode would take extra samples, and every later word would drift.

Samples carry junk in their upper bits, and all six word-length codes are used. A wrong decode or a wrong alignment would therefore leak stray bits or cut words short. A 16-word frame checks the frame-length count.

A frame shorter than its words checks the mid-word restart. A missing sample checks the zero word, the single underflow pulse and the loss of that slot.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

  // Word-length code to bit count; unused codes fall back to the widest word.
  function automatic int wlen_bits(input logic [2:0] code);
    case (code)
      3'd0:    return 8;
      3'd1:    return 12;
      3'd2:    return 16;
      3'd3:    return 20;
      3'd4:    return 24;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/aud_tx_fsedge.sv
module aud_tx_fsedge (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic fsync,
  input  logic cfg_dual,
  output logic phase_start
);
  logic fs_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) fs_prev <= 1'b0;
    else if (bit_tick) fs_prev <= fsync;
  end

  // Rising edge always opens a phase; falling edge only in dual-phase mode.
  assign phase_start = bit_tick &
                       ((fsync & ~fs_prev) | (cfg_dual & ~fsync & fs_prev));
endmodule

// File: rtl/aud_tx_seq.sv
module aud_tx_seq #(
  parameter int FRLEN_W = 7,
  parameter int CNT_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_tick,
  input  logic               phase_start,
  input  logic               cfg_delay,
  input  logic [FRLEN_W-1:0] cfg_frlen,
  input  logic [CNT_W-1:0]   word_bits,
  output logic               word_start,
  output logic               bit_shift,
  output logic               pend_o
);
  logic               pend;
  logic               active;
  logic [CNT_W-1:0]   bits_sent;
  logic [FRLEN_W-1:0] words_left;
  logic               word_done;
  logic               more_words;

  assign word_done  = (bits_sent == word_bits);
  assign more_words = (words_left != '0);
  assign pend_o     = pend;

  always_comb begin
    word_start = 1'b0;
    bit_shift  = 1'b0;
    if (bit_tick) begin
      if (phase_start)      word_start = ~cfg_delay;
      else if (pend)        word_start = 1'b1;
      else if (active) begin
        word_start = word_done & more_words;
        bit_shift  = ~word_done;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      active     <= 1'b0;
      bits_sent  <= '0;
      words_left <= '0;
    end else if (bit_tick) begin
      if (phase_start) begin
        words_left <= cfg_frlen;
        pend       <= cfg_delay;
        active     <= ~cfg_delay;
        bits_sent  <= CNT_W'(1);
      end else if (pend) begin
        pend      <= 1'b0;
        active    <= 1'b1;
        bits_sent <= CNT_W'(1);
      end else if (active) begin
        if (word_done) begin
          if (more_words) begin
            words_left <= words_left - FRLEN_W'(1);
            bits_sent  <= CNT_W'(1);
          end else begin
            active <= 1'b0;
          end
        end else begin
          bits_sent <= bits_sent + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/aud_tx_shift.sv
module aud_tx_shift #(
  parameter int SAMPLE_W = 32,
  parameter int CNT_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_tick,
  input  logic                word_start,
  input  logic                bit_shift,
  input  logic                s_valid,
  input  logic [SAMPLE_W-1:0] s_data,
  input  logic [CNT_W-1:0]    word_bits,
  output logic                sdata_out,
  output logic                underflow
);
  logic [SAMPLE_W-1:0] shreg;
  logic [SAMPLE_W-1:0] aligned;
  logic [CNT_W-1:0]    lshift;

  // Left-align the active word so the MSB sits at the top; junk above W falls off.
  assign lshift  = CNT_W'(SAMPLE_W) - word_bits;
  assign aligned = s_valid ? (s_data << lshift) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg     <= '0;
      sdata_out <= 1'b0;
      underflow <= 1'b0;
    end else begin
      underflow <= word_start & ~s_valid;
      if (bit_tick) begin
        if (word_start) begin
          sdata_out <= aligned[SAMPLE_W-1];
          shreg     <= aligned << 1;
        end else if (bit_shift) begin
          sdata_out <= shreg[SAMPLE_W-1];
          shreg     <= shreg << 1;
        end else begin
          sdata_out <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dual_phase_tx.sv
module dual_phase_tx #(
  parameter int SAMPLE_W = 32,
  parameter int FRLEN_W  = 7,
  parameter int WLEN_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_tick,
  input  logic                fsync,
  input  logic [WLEN_W-1:0]   cfg_wlen,
  input  logic [FRLEN_W-1:0]  cfg_frlen,
  input  logic                cfg_dual,
  input  logic                cfg_delay,
  input  logic [SAMPLE_W-1:0] s_data,
  input  logic                s_valid,
  output logic                s_ready,
  output logic                sdata_out,
  output logic                underflow
);
  import aud_tx_pkg::*;

  localparam int CNT_W = $clog2(SAMPLE_W + 1);

  logic             phase_start;
  logic             word_start;
  logic             bit_shift;
  logic             pend;
  logic [CNT_W-1:0] word_bits;

  assign word_bits = CNT_W'(wlen_bits(3'(cfg_wlen)));
  assign s_ready   = word_start;

  aud_tx_fsedge u_edge (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .fsync(fsync),
    .cfg_dual(cfg_dual), .phase_start(phase_start)
  );

  aud_tx_seq #(.FRLEN_W(FRLEN_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .phase_start(phase_start),
    .cfg_delay(cfg_delay), .cfg_frlen(cfg_frlen), .word_bits(word_bits),
    .word_start(word_start), .bit_shift(bit_shift), .pend_o(pend)
  );

  aud_tx_shift #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .word_start(word_start),
    .bit_shift(bit_shift), .s_valid(s_valid), .s_data(s_data),
    .word_bits(word_bits), .sdata_out(sdata_out), .underflow(underflow)
  );
endmodule

// File: rtl/dual_phase_tx_chk.sv
module dual_phase_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic cfg_delay,
  input logic s_valid,
  input logic s_ready,
  input logic sdata_out,
  input logic underflow,
  input logic phase_start,
  input logic pend
);
  assert_ready_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> bit_tick);

  assert_data_moves_after_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_tick) |-> $stable(sdata_out));

  assert_underflow_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> $past(s_ready && !s_valid));

  assert_no_delay_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_start && !cfg_delay) |-> s_ready);

  assert_delay_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_start && cfg_delay) |-> !s_ready);

  assert_delay_gap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_start && cfg_delay) |=> !sdata_out);

  assert_delayed_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && pend && !phase_start) |-> s_ready);
endmodule

bind dual_phase_tx dual_phase_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .cfg_delay(cfg_delay),
  .s_valid(s_valid), .s_ready(s_ready), .sdata_out(sdata_out),
  .underflow(underflow), .phase_start(phase_start), .pend(pend)
);

// File: tb/sim_dual_phase_tx.sv
module sim_dual_phase_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_tick = 1'b0;
  logic        fsync = 1'b0;
  logic [2:0]  cfg_wlen = 3'd2;
  logic [6:0]  cfg_frlen = 7'd0;
  logic        cfg_dual = 1'b0;
  logic        cfg_delay = 1'b0;
  logic [31:0] s_data = '0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic        sdata_out;
  logic        underflow;

  int checks = 0;
  int failures = 0;
  int uf_seen = 0;
  int sup_rd = 0;
  int mdl_rd = 0;
  bit done = 1'b0;
  logic prev_tick = 1'b0;

  logic [31:0] sup_data[$];
  bit          sup_ok[$];
  bit          exp_bit_q[$];
  string       exp_tag_q[$];

  always #2.5 clk = ~clk;

  dual_phase_tx u0 (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .fsync(fsync),
    .cfg_wlen(cfg_wlen), .cfg_frlen(cfg_frlen), .cfg_dual(cfg_dual),
    .cfg_delay(cfg_delay), .s_data(s_data), .s_valid(s_valid),
    .s_ready(s_ready), .sdata_out(sdata_out), .underflow(underflow)
  );

  function automatic int bits_of(input logic [2:0] c);
    int t[8] = '{8, 12, 16, 20, 24, 32, 32, 32};
    return t[c];
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Monitor: compare the bit driven after each tick against the scoreboard.
  always @(posedge clk) prev_tick <= bit_tick;

  always @(negedge clk) begin
    if (rst_n && underflow) uf_seen++;
    if (prev_tick && exp_bit_q.size() > 0) begin
      bit    b;
      string tg;
      b  = exp_bit_q.pop_front();
      tg = exp_tag_q.pop_front();
      check(sdata_out === b, tg, int'(sdata_out), int'(b));
    end
  end

  task automatic add_sample(input logic [31:0] d, input bit ok);
    sup_data.push_back(d);
    sup_ok.push_back(ok);
  endtask

  task automatic run_frame(input logic [2:0] wc, input int n, input bit dual,
                           input bit dly, input int half, input string tag);
    int w;
    int total;
    int uf_exp;
    int uf0;
    bit expv[];
    w      = bits_of(wc);
    total  = 2 * half;
    uf_exp = 0;
    expv   = new[total];
    foreach (expv[i]) expv[i] = 1'b0;
    for (int ph = 0; ph < (dual ? 2 : 1); ph++) begin
      int ps;
      int pe;
      ps = ph * half;
      pe = dual ? ps + half : total;
      for (int k = 0; k < n; k++) begin
        int st;
        st = ps + dly + k * w;
        if (st < pe) begin
          bit ok;
          logic [31:0] d;
          ok = (mdl_rd < sup_ok.size()) ? sup_ok[mdl_rd] : 1'b0;
          d  = (mdl_rd < sup_data.size()) ? sup_data[mdl_rd] : '0;
          mdl_rd++;
          if (!ok) uf_exp++;
          for (int b = 0; b < w; b++)
            if (st + b < pe) expv[st + b] = ok ? d[w - 1 - b] : 1'b0;
        end
      end
    end
    cfg_wlen  = wc;
    cfg_frlen = 7'(n - 1);
    cfg_dual  = dual;
    cfg_delay = dly;
    uf0 = uf_seen;
    for (int t = 0; t < total; t++) begin
      fsync    = dual ? (t < half) : (t == 0);
      bit_tick = 1'b1;
      s_data   = (sup_rd < sup_data.size()) ? sup_data[sup_rd] : '0;
      s_valid  = (sup_rd < sup_ok.size()) ? sup_ok[sup_rd] : 1'b0;
      exp_bit_q.push_back(expv[t]);
      exp_tag_q.push_back(tag);
      #1;
      if (s_ready) sup_rd++;
      @(posedge clk);
      @(negedge clk);
      bit_tick = 1'b0;
      #1;
      check(s_ready === 1'b0, "R9 ready outside tick", int'(s_ready), 0);
      repeat (2) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    check(uf_seen - uf0 == uf_exp, {tag, " R8 underflow pulses"}, uf_seen - uf0, uf_exp);
    check(sup_rd == mdl_rd, {tag, " R4 samples taken"}, sup_rd, mdl_rd);
  endtask

  initial begin
    #(5 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(sdata_out === 1'b0, "R11 reset sdata", int'(sdata_out), 0);
    check(underflow === 1'b0, "R11 reset underflow", int'(underflow), 0);
    check(s_ready === 1'b0, "R11 reset ready", int'(s_ready), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // I2S stereo: dual phase, 16-bit words, 1-bit delay, 20-bit slots.
    for (int i = 0; i < 4; i++) add_sample(32'hABCD_0000 | (32'h1357 * (i + 3)), 1'b1);
    run_frame(3'd2, 1, 1'b1, 1'b1, 20, "R1 R3 R6 R7 i2s");
    run_frame(3'd2, 1, 1'b1, 1'b1, 20, "R1 R3 R6 R7 i2s");

    // Left-justified: 32-bit words filling each phase, no delay.
    add_sample(32'hF00D_C0DE, 1'b1);
    add_sample(32'h8000_0001, 1'b1);
    run_frame(3'd5, 1, 1'b1, 1'b0, 32, "R1 R3 R5 leftj");

    // DSP with 1-bit delay: four 16-bit words, single phase.
    for (int i = 0; i < 4; i++) add_sample(32'h5A5A_0000 ^ (32'h0F1E * (i + 1)), 1'b1);
    run_frame(3'd2, 4, 1'b0, 1'b1, 35, "R2 R4 R6 R7 dspa");

    // DSP with no delay: three 24-bit words.
    for (int i = 0; i < 3; i++) add_sample(32'hEE00_0000 | (32'h0A_5C3B * (i + 1)), 1'b1);
    run_frame(3'd4, 3, 1'b0, 1'b0, 40, "R1 R4 R5 R7 dspb");

    // Remaining word-length codes: 8, 12, 20 bits.
    for (int c = 0; c < 4; c++) begin
      if (c == 2) continue;
      add_sample(32'hFFFF_F5A3 - 32'(c), 1'b1);
      add_sample(32'h1234_5A69 + 32'(c), 1'b1);
      run_frame(3'(c), 2, 1'b0, 1'b0, 25, "R1 codes");
    end

    // Underflow: second sample of a stereo frame missing.
    add_sample(32'h0000_BEEF, 1'b1);
    add_sample(32'h0000_FFFF, 1'b0);
    add_sample(32'h0000_7E57, 1'b1);
    add_sample(32'h0000_C001, 1'b1);
    run_frame(3'd2, 1, 1'b1, 1'b1, 20, "R8 underflow");
    run_frame(3'd2, 1, 1'b1, 1'b1, 20, "R8 recover");

    // Sixteen 8-bit channels in one frame.
    for (int i = 0; i < 16; i++) add_sample(32'h00A0_0000 | 32'((i * 37 + 11) & 255), 1'b1);
    run_frame(3'd0, 16, 1'b0, 1'b0, 65, "R2 sixteen channels");

    // Frame shorter than its words: second word is cut by the next frame.
    for (int i = 0; i < 4; i++) add_sample(32'h0000_FFFF - 32'(i * 4369), 1'b1);
    run_frame(3'd2, 2, 1'b0, 1'b0, 10, "R10 restart");
    run_frame(3'd2, 2, 1'b0, 1'b0, 10, "R10 restart");
    for (int i = 0; i < 2; i++) add_sample(32'h0000_96C3 + 32'(i), 1'b1);
    run_frame(3'd2, 2, 1'b0, 1'b1, 20, "R10 after restart");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule